// File: doc/BRIEF.md
# Masked Packed Unsigned Minimum Unit

This execution slice takes two packed vector operands of up to 512 bits and returns, lane by lane, the smaller of each pair when both are read as unsigned integers. Each operation chooses its element width (32 or 64 bits) and its active vector length (128, 256 or 512 bits). A 16-bit mask can enable lanes one at a time. A lane that the mask disables either keeps the old destination contents or is cleared to zero.

In masked operation the lowest element of the second operand can be replicated across all lanes. The bits of the destination above the active length follow one of two rules. In the two-operand legacy form they keep the old destination value. In every other form they are cleared.

The caller presents the operands, the old destination value and the controls together with a one-cycle `start` strobe. The result is registered on that clock edge, and `valid` is high for exactly the following cycle.

Top module: `vmin_unit`

## Requirements
- R1: Each active, enabled lane yields the first operand element when it is strictly smaller (unsigned) than the second operand element, and the second operand element otherwise, so ties return the second operand.
- R2: `wide`=0 selects 32-bit lanes and `wide`=1 selects 64-bit lanes. `vlen` codes 0, 1 and 2 select 128, 256 and 512 active bits, and code 3 acts as 512. Lane j occupies bits [j*W +: W].
- R3: `mode` 0 is the legacy two-operand form, 1 is the plain three-operand form, 2 is the masked form, and 3 acts as 1. In the plain form every active lane is computed and `mask` has no effect.
- R4: In the masked form, lane j is computed only if `mask[j]` is 1. With `zeroing`=0, a lane whose mask bit is 0 takes the old destination bits of that lane.
- R5: In the masked form with `zeroing`=1, a lane whose mask bit is 0 is written as zero.
- R6: In the masked form with `bcast`=1, every lane compares its first operand element against `src2[W-1:0]` instead of its own second operand element.
- R7: `bcast` has no effect in the legacy and plain forms.
- R8: In the legacy form the first operand is taken from `dest_old`, and `src1` and `vlen` are ignored. The active length is 128 bits, and result bits 511:128 equal `dest_old` bits 511:128.
- R9: In the plain and masked forms, result bits at and above the active length are zero.
- R10: Mask bits at or above the active lane count have no effect on the result.
- R11: `result` and `valid` update on the rising edge at which `start` is 1. `valid` is 1 for exactly the cycle after each such edge, and `result` holds its value while `start` is 0.
- R12: A synchronous active-high `rst` clears `result` and `valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe; the operation is captured on this edge |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector |
| dest_old | input | 512 | Previous destination contents |
| wide | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| vlen | input | 2 | Active length code: 0=128, 1=256, 2/3=512 |
| mode | input | 2 | 0 legacy, 1 plain, 2 masked, 3 as plain |
| zeroing | input | 1 | Masked-off lanes: 0 keep old, 1 clear |
| bcast | input | 1 | Replicate lowest second-operand element (masked form only) |
| mask | input | 16 | Per-lane enable, bit j for lane j |
| result | output | 512 | Registered result vector |
| valid | output | 1 | High for one cycle after each start |

## Verification
The bench targets equal lane pairs and values with the top bit set. A design that picks the wrong operand on a tie, or that compares signed, returns the other element there. It runs each width at every length, including code 3, and sets mask bits above the lane count. A design that decodes lanes or lengths badly leaks minima into bits that must stay zero or keep their old value. Broadcast is driven in all three forms, and the legacy form is given a `src1` that differs from `dest_old`, so a design that honours broadcast outside the masked form or reads the wrong first operand gives visibly wrong lanes. Further checks cover idle cycles, back-to-back strobes and reset after an operation, which expose result registers that drift or strobes that stretch.

// File: rtl/vmin_pkg.sv
package vmin_pkg;

    localparam int VMAX_W   = 512;
    localparam int CHUNK_W  = 32;
    localparam int NCHUNK   = VMAX_W / CHUNK_W;
    localparam int MASK_W   = NCHUNK;
    localparam int LEGACY_W = 128;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        OP_LEGACY = 2'd0,
        OP_PLAIN  = 2'd1,
        OP_MASKED = 2'd2,
        OP_RSVD   = 2'd3
    } opmode_e;

    typedef struct packed {
        logic              wide;
        vlen_e             vlen;
        opmode_e           mode;
        logic              zeroing;
        logic              bcast;
        logic [MASK_W-1:0] mask;
    } ctl_t;

    typedef struct packed {
        logic              legacy;
        logic              wide;
        logic              zeroing;
        logic              bcast_eff;
        logic [NCHUNK-1:0] active;
        logic [NCHUNK-1:0] enable;
    } plan_t;

    // number of 32-bit chunks covered by the active length
    function automatic int unsigned active_chunks(input vlen_e vl, input logic legacy);
        if (legacy || vl == VL_128) return LEGACY_W / CHUNK_W;
        if (vl == VL_256)           return (2 * LEGACY_W) / CHUNK_W;
        return VMAX_W / CHUNK_W;
    endfunction

endpackage

// File: rtl/vmin_ctl_decode.sv
module vmin_ctl_decode
    import vmin_pkg::*;
#(
    parameter int NCH = NCHUNK
) (
    input  ctl_t  ctl,
    output plan_t plan
);
    logic        legacy;
    logic        masked;
    int unsigned n_act;

    always_comb begin
        legacy = (ctl.mode == OP_LEGACY);
        masked = (ctl.mode == OP_MASKED);
        n_act  = active_chunks(ctl.vlen, legacy);
    end

    always_comb begin
        plan.legacy    = legacy;
        plan.wide      = ctl.wide;
        plan.zeroing   = ctl.zeroing;
        plan.bcast_eff = masked && ctl.bcast;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_chunk
        localparam int LANE_N = k;
        localparam int LANE_W = k / 2;
        logic act;
        logic bit_on;
        always_comb begin
            act    = (k < n_act);
            bit_on = ctl.wide ? ctl.mask[LANE_W] : ctl.mask[LANE_N];
            plan.active[k] = act;
            plan.enable[k] = act && (!masked || bit_on);
        end
    end

    // R10: no chunk outside the active length may ever be enabled
    always_comb begin
        enable_in_range_chk: assert ((plan.enable & ~plan.active) == '0);
    end

endmodule

// File: rtl/vmin_operand_sel.sv
module vmin_operand_sel
    import vmin_pkg::*;
#(
    parameter int VW = VMAX_W,
    parameter int CW = CHUNK_W
) (
    input  logic [VW-1:0] src1,
    input  logic [VW-1:0] src2,
    input  logic [VW-1:0] dest_old,
    input  plan_t         plan,
    output logic [VW-1:0] op_a,
    output logic [VW-1:0] op_b
);
    localparam int NCH = VW / CW;

    assign op_a = plan.legacy ? dest_old : src1;

    for (genvar k = 0; k < NCH; k++) begin : g_b
        localparam int HALF = k % 2;
        always_comb begin
            if (!plan.bcast_eff)
                op_b[k*CW +: CW] = src2[k*CW +: CW];
            else if (plan.wide)
                op_b[k*CW +: CW] = src2[HALF*CW +: CW];
            else
                op_b[k*CW +: CW] = src2[CW-1:0];
        end
    end

endmodule

// File: rtl/vmin_lane_min.sv
module vmin_lane_min
    import vmin_pkg::*;
#(
    parameter int VW = VMAX_W,
    parameter int CW = CHUNK_W
) (
    input  logic [VW-1:0] op_a,
    input  logic [VW-1:0] op_b,
    input  logic          wide,
    output logic [VW-1:0] min_v
);
    localparam int WW  = 2 * CW;
    localparam int NS  = VW / CW;
    localparam int NW  = VW / WW;

    logic [VW-1:0] min_s;
    logic [VW-1:0] min_w;

    for (genvar g = 0; g < NS; g++) begin : g_small
        logic [CW-1:0] a, b, m;
        always_comb begin
            a = op_a[g*CW +: CW];
            b = op_b[g*CW +: CW];
            m = (a < b) ? a : b;
            min_s[g*CW +: CW] = m;
        end
        // R1
        always_comb begin
            min_small_chk: assert (m <= a && m <= b && (m == a || m == b));
        end
    end

    for (genvar g = 0; g < NW; g++) begin : g_wide
        logic [WW-1:0] a, b, m;
        always_comb begin
            a = op_a[g*WW +: WW];
            b = op_b[g*WW +: WW];
            m = (a < b) ? a : b;
            min_w[g*WW +: WW] = m;
        end
        // R1
        always_comb begin
            min_wide_chk: assert (m <= a && m <= b && (m == a || m == b));
        end
    end

    assign min_v = wide ? min_w : min_s;

endmodule

// File: rtl/vmin_write_merge.sv
module vmin_write_merge
    import vmin_pkg::*;
#(
    parameter int VW = VMAX_W,
    parameter int CW = CHUNK_W
) (
    input  logic [VW-1:0] min_v,
    input  logic [VW-1:0] dest_old,
    input  plan_t         plan,
    output logic [VW-1:0] next_v
);
    localparam int NCH = VW / CW;

    for (genvar k = 0; k < NCH; k++) begin : g_w
        always_comb begin
            if (plan.enable[k])
                next_v[k*CW +: CW] = min_v[k*CW +: CW];
            else if (plan.active[k])
                next_v[k*CW +: CW] = plan.zeroing ? '0 : dest_old[k*CW +: CW];
            else
                next_v[k*CW +: CW] = plan.legacy ? dest_old[k*CW +: CW] : '0;
        end
    end

endmodule

// File: rtl/vmin_unit.sv
module vmin_unit
    import vmin_pkg::*;
#(
    parameter int VW = VMAX_W,
    parameter int CW = CHUNK_W,
    parameter int MW = MASK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [VW-1:0] src1,
    input  logic [VW-1:0] src2,
    input  logic [VW-1:0] dest_old,
    input  logic          wide,
    input  logic [1:0]    vlen,
    input  logic [1:0]    mode,
    input  logic          zeroing,
    input  logic          bcast,
    input  logic [MW-1:0] mask,
    output logic [VW-1:0] result,
    output logic          valid
);
    ctl_t          ctl;
    plan_t         plan;
    logic [VW-1:0] op_a, op_b, min_v, next_v;

    always_comb begin
        ctl.wide    = wide;
        ctl.vlen    = vlen_e'(vlen);
        ctl.mode    = opmode_e'(mode);
        ctl.zeroing = zeroing;
        ctl.bcast   = bcast;
        ctl.mask    = mask;
    end

    vmin_ctl_decode #(.NCH(VW / CW)) u_dec (
        .ctl  (ctl),
        .plan (plan)
    );

    vmin_operand_sel #(.VW(VW), .CW(CW)) u_sel (
        .src1     (src1),
        .src2     (src2),
        .dest_old (dest_old),
        .plan     (plan),
        .op_a     (op_a),
        .op_b     (op_b)
    );

    vmin_lane_min #(.VW(VW), .CW(CW)) u_min (
        .op_a  (op_a),
        .op_b  (op_b),
        .wide  (plan.wide),
        .min_v (min_v)
    );

    vmin_write_merge #(.VW(VW), .CW(CW)) u_mrg (
        .min_v    (min_v),
        .dest_old (dest_old),
        .plan     (plan),
        .next_v   (next_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= start;
            if (start) result <= next_v;
        end
    end

    // R11
    valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);

    // R11
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));

    // R8
    legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == OP_LEGACY) |=>
            result[VW-1:LEGACY_W] == $past(dest_old[VW-1:LEGACY_W]));

    // R9
    clear_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode != OP_LEGACY && vlen == VL_128) |=>
            result[VW-1:LEGACY_W] == '0);

endmodule

// File: tb/vmin_unit_tb_top.sv
module vmin_unit_tb_top;

    localparam int VW = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [VW-1:0] src1 = '0, src2 = '0, dest_old = '0;
    logic          wide = 1'b0;
    logic [1:0]    vlen = 2'd0;
    logic [1:0]    mode = 2'd0;
    logic          zeroing = 1'b0;
    logic          bcast = 1'b0;
    logic [15:0]   mask = '0;
    logic [VW-1:0] result;
    logic          valid;

    always #10 clk = ~clk;

    vmin_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .src1(src1), .src2(src2),
        .dest_old(dest_old), .wide(wide), .vlen(vlen), .mode(mode),
        .zeroing(zeroing), .bcast(bcast), .mask(mask),
        .result(result), .valid(valid)
    );

    typedef struct {
        logic [VW-1:0] val;
        string         tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [VW-1:0] last_exp = '0;
    int            n_chk = 0;
    int            n_fail = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent reference built from the requirement text
    function automatic logic [VW-1:0] model(
        input logic [VW-1:0] s1, input logic [VW-1:0] s2, input logic [VW-1:0] old,
        input logic e64, input logic [1:0] vl, input logic [1:0] md,
        input logic zr, input logic bc, input logic [15:0] mk);
        int ew    = e64 ? 64 : 32;
        bit leg   = (md == 2'd0);
        bit msk   = (md == 2'd2);
        int vbits = leg ? 128 : (vl == 2'd0 ? 128 : (vl == 2'd1 ? 256 : 512));
        logic [VW-1:0] wm = (e64 ? {{(VW-64){1'b0}}, {64{1'b1}}} : {{(VW-32){1'b0}}, {32{1'b1}}});
        logic [VW-1:0] r  = leg ? old : '0;
        for (int j = 0; j < vbits / ew; j++) begin
            logic [VW-1:0] a, b, o, v;
            a = ((leg ? old : s1) >> (j * ew)) & wm;
            b = ((msk && bc) ? s2 : (s2 >> (j * ew))) & wm;
            o = (old >> (j * ew)) & wm;
            if (!msk || mk[j]) v = (a < b) ? a : b;
            else               v = zr ? '0 : o;
            r = (r & ~(wm << (j * ew))) | (v << (j * ew));
        end
        return r;
    endfunction

    task automatic issue(input logic [VW-1:0] s1, input logic [VW-1:0] s2,
                         input logic [VW-1:0] old, input logic e64,
                         input logic [1:0] vl, input logic [1:0] md,
                         input logic zr, input logic bc, input logic [15:0] mk,
                         input string tag);
        exp_t e;
        @(negedge clk);
        src1 = s1; src2 = s2; dest_old = old; wide = e64; vlen = vl;
        mode = md; zeroing = zr; bcast = bc; mask = mk; start = 1'b1;
        e.val = model(s1, s2, old, e64, vl, md, zr, bc, mk);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // monitor: pops the scoreboard when a result appears
    always @(negedge clk) begin
        if (!rst && valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 valid without a pending operation", result, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                last_exp = e.val;
                check(result === e.val, e.tag, result, e.val);
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [VW-1:0] a, b, o, tie;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12
        check(result === '0 && valid === 1'b0, "R12 reset state", result, '0);

        a = rnd_vec(); b = rnd_vec(); o = rnd_vec();
        tie = a;
        tie[31:0]   = 32'hFFFF_FFFF;
        a[31:0]     = 32'hFFFF_FFFE;
        tie[63:32]  = 32'h8000_0000;
        a[63:32]    = 32'h0000_0001;

        issue(a, tie, o, 0, 2'd2, 2'd1, 0, 0, 16'h0000, "R1 ties and top-bit values 32b");
        issue(a, a,   o, 1, 2'd2, 2'd1, 0, 0, 16'h0000, "R1 all ties 64b");
        issue(a, b, o, 0, 2'd0, 2'd1, 0, 0, 16'hFFFF, "R2 R9 32b len128");
        issue(a, b, o, 0, 2'd1, 2'd1, 0, 0, 16'h0000, "R2 R9 32b len256");
        issue(a, b, o, 1, 2'd1, 2'd1, 0, 0, 16'h0000, "R2 R9 64b len256");
        issue(a, b, o, 1, 2'd2, 2'd1, 0, 0, 16'h0000, "R2 64b len512");
        issue(a, b, o, 0, 2'd3, 2'd1, 0, 0, 16'h0000, "R2 len code 3 as 512");
        issue(a, b, o, 0, 2'd2, 2'd3, 0, 0, 16'h1234, "R3 mode 3 as plain");
        issue(a, b, o, 0, 2'd2, 2'd1, 0, 1, 16'h5A5A, "R3 R7 plain ignores mask and bcast");
        issue(a, b, o, 0, 2'd2, 2'd2, 0, 0, 16'hA5C3, "R4 merge masking 32b");
        issue(a, b, o, 1, 2'd2, 2'd2, 0, 0, 16'h0069, "R4 merge masking 64b");
        issue(a, b, o, 0, 2'd1, 2'd2, 1, 0, 16'h00C5, "R5 zero masking 32b");
        issue(a, b, o, 1, 2'd0, 2'd2, 1, 0, 16'h0002, "R5 zero masking 64b");
        issue(a, b, o, 0, 2'd2, 2'd2, 0, 1, 16'hFFFF, "R6 broadcast 32b");
        issue(a, b, o, 1, 2'd2, 2'd2, 1, 1, 16'h00B7, "R6 broadcast 64b zeroing");
        issue(a, b, o, 0, 2'd0, 2'd0, 1, 1, 16'h0000, "R7 R8 legacy ignores bcast");
        issue(a, b, o, 1, 2'd2, 2'd0, 0, 0, 16'h0000, "R8 legacy 64b ignores src1 and vlen");
        issue(a, b, o, 0, 2'd0, 2'd2, 0, 0, 16'hFFF0, "R10 high mask bits ignored 32b");
        issue(a, b, o, 1, 2'd1, 2'd2, 0, 0, 16'hFF00, "R10 high mask bits ignored 64b");
        idle(3);
        // R11
        check(valid === 1'b0, "R11 valid single pulse", {511'b0, valid}, '0);
        check(result === last_exp, "R11 result held while idle", result, last_exp);

        for (int i = 0; i < 60; i++) begin
            logic [VW-1:0] ra, rb;
            ra = rnd_vec(); rb = rnd_vec();
            if (i % 4 == 0) rb = ra;
            if (i % 5 == 0) rb = ra ^ {16{32'h0000_0001}};
            issue(ra, rb, rnd_vec(), 1'($urandom), 2'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom), 16'($urandom), "R1 R4 R5 R6 R9 random mix");
            if (i % 7 == 0) idle(1);
        end
        idle(3);
        check(exp_q.size() == 0, "R11 every start produced a result",
              VW'(exp_q.size()), '0);

        issue(a, b, o, 0, 2'd2, 2'd1, 0, 0, 16'h0000, "R1 before reset");
        idle(2);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        // R12
        check(result === '0 && valid === 1'b0, "R12 reset clears result", result, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule